// File: doc/BRIEF.md
# SD Host Transfer Status Tracker

This block produces the buffer-ready and transfer-active flags of an SD host controller's present-state word. It keeps a count of the entries held in the host-side data buffer and compares that count against two programmable watermarks. One flag tells the system that enough data is waiting to be read. The other tells it that enough free room exists to be written. Both flags serve transfers that software moves through the data port, not DMA.

It also tracks whether a read transfer and a write transfer are in progress. The card-side and system-side engines report protocol events as pulses: command end bit, continue request, last block drained, CRC status received. Two level inputs report a pending stop-at-block-gap and a block in flight on the card bus. Each time an active flag drops because of a protocol event, the block emits a one-cycle transfer-complete pulse for the interrupt logic. With no card present every flag is held at zero.

Top module: `sd_xfer_status`

## Requirements
- R1: The buffer level starts at 0. A push raises it by one and a pop lowers it by one. A push and a pop together leave it unchanged. A push at DEPTH and a pop at 0 are ignored, so push+pop at DEPTH gives DEPTH-1 and push+pop at 0 gives 1.
- R2: `stat_hi[3]` (read ready) is 1 exactly when the level is strictly greater than `rd_wmark`.
- R3: `stat_hi[2]` (write ready) is 1 exactly when the free space (DEPTH minus level) is strictly greater than `wr_wmark`.
- R4: `stat_hi[7:4]` always reads 0.
- R5: `stat_hi[1]` (read active) is 1 after the clock edge that samples `rd_cmd_end`, or that samples `cont_req` with `cont_is_rd`=1.
- R6: Read active clears after the edge that samples `rd_last_drained`. It also clears after the edge that samples `gap_stop`=1 with `card_blk_busy`=0 and a buffer level of 0.
- R7: `stat_hi[0]` (write active) is 1 after the edge that samples `wr_cmd_end`, or that samples `cont_req` with `cont_is_rd`=0.
- R8: Write active clears after the edge that samples `wr_crc_stat` together with either `wr_last_blk`=1 or `gap_stop`=1. A CRC status without either condition leaves it set.
- R9: When a set event and a clear event for the same active flag are sampled in one cycle, the flag ends at 0.
- R10: `xfer_done` is high for exactly one cycle, the cycle in which an active flag first reads 0 after a clear event. No pulse occurs when the flag was already 0, and none occurs on card removal.
- R11: During reset all `stat_hi` bits and `xfer_done` are 0. While `card_present` is 0 the active flags clear after the next edge and the level returns to 0. The buffer-ready flags follow `card_present` delayed by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present | input | 1 | Card detected; 0 forces all flags off |
| push | input | 1 | One entry written into the host buffer |
| pop | input | 1 | One entry taken from the host buffer |
| rd_wmark | input | LW | Read watermark |
| wr_wmark | input | LW | Write watermark |
| rd_cmd_end | input | 1 | End bit of a read command seen |
| wr_cmd_end | input | 1 | End bit of a write command seen |
| cont_req | input | 1 | Software continue request (restart) |
| cont_is_rd | input | 1 | Direction of the restart: 1 read, 0 write |
| rd_last_drained | input | 1 | Last block of the read count taken by the system |
| gap_stop | input | 1 | Stop-at-block-gap request pending |
| card_blk_busy | input | 1 | A block is in flight on the card bus |
| wr_crc_stat | input | 1 | CRC status token of a written block received |
| wr_last_blk | input | 1 | The block whose CRC status arrives is the last one |
| stat_hi | output | 8 | Status byte: [7:4] zero, [3] read ready, [2] write ready, [1] read active, [0] write active |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The watermark function is driven through a table of level and watermark pairs. The table places the level one below, equal to and one above each threshold, and at both extremes of the buffer, so that a strict comparison can be told apart from an inclusive one and free space can be told apart from fill level. Directed runs then push past full, pop below empty and issue push and pop together at both limits. These runs separate a saturating counter from a wrapping one. The active flags are exercised with each set and clear source on its own, with set and clear in one cycle, with a gap stop blocked by a busy block or a non-empty buffer, and with card removal. These runs show which events fire the completion pulse and which must stay silent.

// File: rtl/sdxs_pkg.sv
package sdxs_pkg;
  // Index of each active-flag tracker in the generated array
  localparam int ACT_WR = 0;
  localparam int ACT_RD = 1;
  localparam int N_ACT  = 2;

  typedef struct packed {
    logic [3:0] rsvd;
    logic       rd_buf_en;
    logic       wr_buf_en;
    logic       rd_act;
    logic       wr_act;
  } sdxs_stat_t;
endpackage

// File: rtl/sdxs_level_ctr.sv
module sdxs_level_ctr #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] lvl_q, lvl_d;
  logic          lvl_en;
  logic          push_ok, pop_ok;

  always_comb begin
    push_ok = push && (lvl_q != FULL);
    pop_ok  = pop  && (lvl_q != '0);
    lvl_en  = flush || push_ok || pop_ok;
    lvl_d   = lvl_q;
    if (flush)
      lvl_d = '0;
    else if (push_ok && !pop_ok)
      lvl_d = lvl_q + 1'b1;
    else if (pop_ok && !push_ok)
      lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lvl_q <= '0;
    else if (lvl_en)
      lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/sdxs_wmark_cmp.sv
module sdxs_wmark_cmp #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] rd_wmark,
  input  logic [LW-1:0] wr_wmark,
  input  logic          enable,
  output logic          rd_ready,
  output logic          wr_ready
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] free_sp;

  always_comb begin
    free_sp  = FULL - level;
    rd_ready = enable && (level   > rd_wmark);
    wr_ready = enable && (free_sp > wr_wmark);
  end
endmodule

// File: rtl/sdxs_act_flag.sv
module sdxs_act_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set_evt,
  input  logic clr_evt,
  output logic active,
  output logic fell
);
  logic act_q, act_d;
  logic fell_q, fell_d;

  always_comb begin
    act_d  = act_q;
    fell_d = 1'b0;
    if (kill)
      act_d = 1'b0;
    else if (clr_evt) begin
      act_d  = 1'b0;
      fell_d = act_q;
    end else if (set_evt)
      act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      fell_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      fell_q <= fell_d;
    end
  end

  assign active = act_q;
  assign fell   = fell_q;
endmodule

// File: rtl/sd_xfer_status.sv
module sd_xfer_status
  import sdxs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          card_present,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] rd_wmark,
  input  logic [LW-1:0] wr_wmark,
  input  logic          rd_cmd_end,
  input  logic          wr_cmd_end,
  input  logic          cont_req,
  input  logic          cont_is_rd,
  input  logic          rd_last_drained,
  input  logic          gap_stop,
  input  logic          card_blk_busy,
  input  logic          wr_crc_stat,
  input  logic          wr_last_blk,
  output logic [7:0]    stat_hi,
  output logic          xfer_done
);
  logic [LW-1:0]    lvl;
  logic             card_ok_q;
  logic             rd_ready, wr_ready;
  logic [N_ACT-1:0] set_v, clr_v, act_v, fell_v;
  sdxs_stat_t       stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      card_ok_q <= 1'b0;
    else
      card_ok_q <= card_present;
  end

  sdxs_level_ctr #(.DEPTH(DEPTH), .LW(LW)) u_lvl (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!card_present),
    .push  (push),
    .pop   (pop),
    .level (lvl)
  );

  sdxs_wmark_cmp #(.DEPTH(DEPTH), .LW(LW)) u_cmp (
    .level    (lvl),
    .rd_wmark (rd_wmark),
    .wr_wmark (wr_wmark),
    .enable   (card_ok_q),
    .rd_ready (rd_ready),
    .wr_ready (wr_ready)
  );

  always_comb begin
    set_v[ACT_RD] = rd_cmd_end || (cont_req && cont_is_rd);
    clr_v[ACT_RD] = rd_last_drained ||
                    (gap_stop && !card_blk_busy && (lvl == '0));
    set_v[ACT_WR] = wr_cmd_end || (cont_req && !cont_is_rd);
    clr_v[ACT_WR] = wr_crc_stat && (wr_last_blk || gap_stop);
  end

  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    sdxs_act_flag u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (!card_present),
      .set_evt (set_v[g]),
      .clr_evt (clr_v[g]),
      .active  (act_v[g]),
      .fell    (fell_v[g])
    );
  end

  always_comb begin
    stat.rsvd      = '0;
    stat.rd_buf_en = rd_ready;
    stat.wr_buf_en = wr_ready;
    stat.rd_act    = act_v[ACT_RD];
    stat.wr_act    = act_v[ACT_WR];
  end

  assign stat_hi   = stat;
  assign xfer_done = |fell_v;
endmodule

// File: rtl/sdxs_chk.sv
module sdxs_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          card_present,
  input logic          rd_cmd_end,
  input logic          wr_cmd_end,
  input logic          rd_last_drained,
  input logic          gap_stop,
  input logic          wr_crc_stat,
  input logic          wr_last_blk,
  input logic [7:0]    stat_hi,
  input logic          xfer_done,
  input logic [LW-1:0] level
);
  // R1: the level never passes the buffer depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R5: a read command end bit starts the read transfer
  a_r5_rd_set: assert property (@(posedge clk) disable iff (!rst_n)
    (card_present && rd_cmd_end && !rd_last_drained && !gap_stop) |=> stat_hi[1]);

  // R7: a write command end bit starts the write transfer
  a_r7_wr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (card_present && wr_cmd_end && !wr_crc_stat) |=> stat_hi[0]);

  // R8: CRC status of the last block ends the write transfer
  a_r8_wr_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_crc_stat && wr_last_blk) |=> !stat_hi[0]);

  // R10: the completion pulse only follows an active flag going low
  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ($fell(stat_hi[1]) || $fell(stat_hi[0])));

  // R10: the completion pulse never lasts two cycles
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R11: card absent clears both active flags at the next edge
  a_r11_no_card: assert property (@(posedge clk) disable iff (!rst_n)
    !card_present |=> (stat_hi[1:0] == 2'b00) && !xfer_done);
endmodule

bind sd_xfer_status sdxs_chk #(.DEPTH(DEPTH), .LW(LW)) u_sdxs_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .card_present    (card_present),
  .rd_cmd_end      (rd_cmd_end),
  .wr_cmd_end      (wr_cmd_end),
  .rd_last_drained (rd_last_drained),
  .gap_stop        (gap_stop),
  .wr_crc_stat     (wr_crc_stat),
  .wr_last_blk     (wr_last_blk),
  .stat_hi         (stat_hi),
  .xfer_done       (xfer_done),
  .level           (lvl)
);

// File: tb/sd_xfer_status_tb.sv
`timescale 1ns/1ps
module sd_xfer_status_tb_top;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NV    = 7;
  // vector: {level, rd_wmark, wr_wmark, exp read ready, exp write ready}
  localparam logic [3*LW+1:0] VT [NV] = '{
    {5'd0,  5'd0,  5'd15, 1'b0, 1'b1},
    {5'd5,  5'd4,  5'd11, 1'b1, 1'b0},
    {5'd5,  5'd5,  5'd10, 1'b0, 1'b1},
    {5'd16, 5'd15, 5'd0,  1'b1, 1'b0},
    {5'd16, 5'd16, 5'd0,  1'b0, 1'b0},
    {5'd8,  5'd7,  5'd7,  1'b1, 1'b1},
    {5'd1,  5'd0,  5'd16, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic card_present, push, pop;
  logic [LW-1:0] rd_wmark, wr_wmark;
  logic rd_cmd_end, wr_cmd_end, cont_req, cont_is_rd;
  logic rd_last_drained, gap_stop, card_blk_busy, wr_crc_stat, wr_last_blk;
  logic [7:0] stat_hi;
  logic xfer_done;

  int checks = 0;
  int errors = 0;
  int mlvl   = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  sd_xfer_status #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .card_present(card_present),
    .push(push), .pop(pop), .rd_wmark(rd_wmark), .wr_wmark(wr_wmark),
    .rd_cmd_end(rd_cmd_end), .wr_cmd_end(wr_cmd_end),
    .cont_req(cont_req), .cont_is_rd(cont_is_rd),
    .rd_last_drained(rd_last_drained), .gap_stop(gap_stop),
    .card_blk_busy(card_blk_busy), .wr_crc_stat(wr_crc_stat),
    .wr_last_blk(wr_last_blk), .stat_hi(stat_hi), .xfer_done(xfer_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // all pulse inputs low; advance one clock; outputs read at the following negedge
  task automatic tick();
    @(negedge clk);
    push = 0; pop = 0; rd_cmd_end = 0; wr_cmd_end = 0; cont_req = 0;
    rd_last_drained = 0; wr_crc_stat = 0;
  endtask

  task automatic step_push(); push = 1; mlvl = (mlvl < DEPTH) ? mlvl + 1 : mlvl; tick(); endtask
  task automatic step_pop();  pop = 1;  mlvl = (mlvl > 0) ? mlvl - 1 : mlvl;     tick(); endtask

  task automatic go_level(input int target);
    while (mlvl < target) step_push();
    while (mlvl > target) step_pop();
  endtask

  task automatic rd_ready_is(input string req, input int wm, input logic exp);
    rd_wmark = LW'(wm);
    #1 check(req, 32'(stat_hi[3]), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; card_present = 1; push = 0; pop = 0;
    rd_wmark = '0; wr_wmark = '0; rd_cmd_end = 0; wr_cmd_end = 0;
    cont_req = 0; cont_is_rd = 0; rd_last_drained = 0; gap_stop = 0;
    card_blk_busy = 0; wr_crc_stat = 0; wr_last_blk = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset stat", 32'(stat_hi), 32'h0);
    check("R11 reset done", 32'(xfer_done), 32'h0);
    rst_n = 1;
    tick();
    // R4 reserved bits and R3 empty buffer write ready
    check("R4 reserved", 32'(stat_hi[7:4]), 32'h0);
    check("R3 empty write ready", 32'(stat_hi[2]), 32'h1);

    // vector table for R2 / R3
    for (int i = 0; i < NV; i++) begin
      go_level(int'(VT[i][3*LW+1:2*LW+2]));
      rd_wmark = VT[i][2*LW+1:LW+2];
      wr_wmark = VT[i][LW+1:2];
      #1;
      check($sformatf("R2 vec %0d", i), 32'(stat_hi[3]), 32'(VT[i][1]));
      check($sformatf("R3 vec %0d", i), 32'(stat_hi[2]), 32'(VT[i][0]));
    end

    // R1 push at full ignored
    wr_wmark = '0;
    go_level(DEPTH);
    push = 1; tick(); push = 1; tick();
    rd_ready_is("R1 full push", 15, 1'b1);
    pop = 1; tick(); mlvl = DEPTH - 1;
    rd_ready_is("R1 full push ignored", 15, 1'b0);
    rd_ready_is("R1 full push ignored lo", 14, 1'b1);
    // R1 push+pop at full gives DEPTH-1
    go_level(DEPTH);
    push = 1; pop = 1; tick(); mlvl = DEPTH - 1;
    rd_ready_is("R1 both at full", 15, 1'b0);
    rd_ready_is("R1 both at full lo", 14, 1'b1);
    // R1 push+pop mid level unchanged
    go_level(5);
    push = 1; pop = 1; tick();
    rd_ready_is("R1 both mid", 4, 1'b1);
    rd_ready_is("R1 both mid hi", 5, 1'b0);
    // R1 pop at empty ignored, push+pop at empty gives 1
    go_level(0);
    pop = 1; tick(); pop = 1; tick();
    rd_ready_is("R1 empty pop", 0, 1'b0);
    push = 1; pop = 1; tick(); mlvl = 1;
    rd_ready_is("R1 both at empty", 0, 1'b1);
    rd_ready_is("R1 both at empty hi", 1, 1'b0);
    go_level(0);

    // R5 / R6 read active
    rd_cmd_end = 1; tick();
    check("R5 cmd end sets read", 32'(stat_hi[1]), 32'h1);
    check("R10 no pulse on set", 32'(xfer_done), 32'h0);
    rd_last_drained = 1; tick();
    check("R6 last drained clears", 32'(stat_hi[1]), 32'h0);
    check("R10 pulse on read fall", 32'(xfer_done), 32'h1);
    tick();
    check("R10 pulse one cycle", 32'(xfer_done), 32'h0);
    rd_last_drained = 1; tick();
    check("R10 no pulse when idle", 32'(xfer_done), 32'h0);
    cont_is_rd = 1; cont_req = 1; tick();
    check("R5 continue sets read", 32'(stat_hi[1:0]), 32'h2);
    // R6 gap stop blocked by data then by busy block
    step_push(); step_push();
    gap_stop = 1; card_blk_busy = 1;
    step_pop(); step_pop();
    check("R6 gap with busy holds", 32'(stat_hi[1]), 32'h1);
    card_blk_busy = 0; tick();
    check("R6 gap drained clears", 32'(stat_hi[1]), 32'h0);
    check("R10 pulse on gap clear", 32'(xfer_done), 32'h1);
    gap_stop = 0;
    // R9 set and clear together while active
    rd_cmd_end = 1; tick();
    rd_cmd_end = 1; rd_last_drained = 1; tick();
    check("R9 read clear wins", 32'(stat_hi[1]), 32'h0);

    // R7 / R8 write active
    wr_cmd_end = 1; tick();
    check("R7 cmd end sets write", 32'(stat_hi[1:0]), 32'h1);
    wr_crc_stat = 1; wr_last_blk = 0; tick();
    check("R8 mid block crc holds", 32'(stat_hi[0]), 32'h1);
    wr_crc_stat = 1; wr_last_blk = 1; tick();
    check("R8 last crc clears", 32'(stat_hi[0]), 32'h0);
    check("R10 pulse on write fall", 32'(xfer_done), 32'h1);
    wr_last_blk = 0;
    cont_is_rd = 0; cont_req = 1; tick();
    check("R7 continue sets write", 32'(stat_hi[1:0]), 32'h1);
    gap_stop = 1; wr_crc_stat = 1; tick();
    check("R8 gap crc clears", 32'(stat_hi[0]), 32'h0);
    gap_stop = 0;
    wr_cmd_end = 1; tick();
    wr_cmd_end = 1; wr_crc_stat = 1; wr_last_blk = 1; tick();
    check("R9 write clear wins", 32'(stat_hi[0]), 32'h0);
    wr_last_blk = 0;

    // R11 card removal
    rd_cmd_end = 1; wr_cmd_end = 1; tick();
    step_push(); step_push(); step_push();
    rd_wmark = '0; wr_wmark = '0;
    card_present = 0; tick();
    check("R11 no card flags", 32'(stat_hi), 32'h0);
    check("R11 no pulse on removal", 32'(xfer_done), 32'h0);
    card_present = 1; mlvl = 0; tick();
    check("R11 level flushed", 32'(stat_hi), 32'h4);

    finish_run();
  end
endmodule